// File: doc/BRIEF.md
# Sprite Attribute Cache with Display-Mode Write Window

This block keeps an on-chip copy of two of the four 16-bit words in every 8-byte sprite attribute entry. It watches the write stream going into video memory. A write is captured only when its byte address, measured from the table base, falls inside the window that the current display width allows, and only when it targets the vertical-position word (word 0) or the size/link word (word 1) of an entry. Writes to the horizontal-position word and the tile/attribute word (words 2 and 3) pass by without effect.

A single mode input selects the narrow (32-column) or wide (40-column) display. The wide window spans 80 entries (640 bytes). The narrow window spans only entries 0 to 63 (512 bytes). When the narrow display is active, entries 64 to 79 cannot be updated, so they keep whatever they held before. Those old values come back into view after a return to the wide display. The sprite list walker reads the cache by entry number through a registered read port.

Top module: `sprite_attr_cache`

## Requirements
- R1: After reset, every cached entry reads back as zero in both words.
- R2: A write at byte address base + 8*n (word 0) stores the data as the vertical-position word of entry n.
- R3: A write at byte address base + 8*n + 2 (word 1) stores the data as the size/link word of entry n.
- R4: Writes at base + 8*n + 4 and base + 8*n + 6 (words 2 and 3) leave entry n unchanged.
- R5: While wide_mode is 0, writes at table offset 512 (entry 64) or above are dropped, and entries 0 to 63 still update.
- R6: While wide_mode is 1, entries 64 to 79 (offsets 512 to 639) are updated.
- R7: Entries 64 to 79 keep their contents through a period in narrow mode and show them again once wide_mode returns to 1.
- R8: Writes below the table base, or at offset 640 or above, change no entry.
- R9: The words for the entry index presented at a clock edge appear on rd_ypos and rd_link after that edge and hold until the next edge.
- R10: A write and a read of the same entry in the same cycle return the newly written word.
- R11: A read index of 80 or above returns zero in both words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 = 40-column display (80 entries), 0 = 32-column display (64 entries) |
| tbl_base | input | 16 | Byte address of the sprite attribute table |
| wr_en | input | 1 | Video-memory write strobe being snooped |
| wr_addr | input | 16 | Byte address of the snooped write (bit 0 ignored) |
| wr_data | input | 16 | Data of the snooped write |
| rd_idx | input | 7 | Entry number requested by the list walker |
| rd_ypos | output | 16 | Cached vertical-position word, one cycle after rd_idx |
| rd_link | output | 16 | Cached size/link word, one cycle after rd_idx |

## Verification
The assertions check these properties on every cycle: the narrow-mode capture window never reaches entries 64 and above, same-cycle forwarding of both words, zero data for indices beyond the table, outputs that hold when the index is steady and nothing is captured, and zero outputs when reset ends. Whether a stale wide-mode entry survives a trip through narrow mode, whether words 2 and 3 and out-of-window addresses truly leave storage untouched, and whether each address lands on the right entry can only be shown by the bench. Its write-then-read scenarios run against a per-cycle behavioural model.

// File: rtl/stc_pkg.sv
package stc_pkg;

   localparam int STC_WORD_W = 16;

   typedef enum logic [1:0] {
      WSEL_YPOS = 2'd0,
      WSEL_LINK = 2'd1,
      WSEL_XPOS = 2'd2,
      WSEL_ATTR = 2'd3
   } stc_wsel_e;

   typedef struct packed {
      logic [STC_WORD_W-1:0] ypos;
      logic [STC_WORD_W-1:0] link;
   } stc_entry_t;

endpackage

// File: rtl/stc_snoop_decode.sv
module stc_snoop_decode
   import stc_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int IDX_W       = 7,
   parameter int N_WIDE      = 80,
   parameter int N_NARROW    = 64,
   parameter int ENTRY_BYTES = 8
) (
   input  logic              wide_mode,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic              cap_hit,
   output logic [IDX_W-1:0]  cap_entry,
   output stc_wsel_e         cap_word
);

   localparam logic [ADDR_W-1:0] LIM_WIDE   = ADDR_W'(N_WIDE * ENTRY_BYTES);
   localparam logic [ADDR_W-1:0] LIM_NARROW = ADDR_W'(N_NARROW * ENTRY_BYTES);

   if (ENTRY_BYTES != 8) begin : g_bad_entry
      $error("stc_snoop_decode: ENTRY_BYTES must be 8");
   end
   if (ADDR_W < IDX_W + 3) begin : g_bad_addr
      $error("stc_snoop_decode: ADDR_W too narrow for IDX_W");
   end

   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] limit;
   logic              in_window;
   logic              cached_word;

   always_comb begin
      offset      = wr_addr - tbl_base;
      limit       = wide_mode ? LIM_WIDE : LIM_NARROW;
      in_window   = offset < limit;
      cap_word    = stc_wsel_e'(offset[2:1]);
      cap_entry   = offset[IDX_W+2:3];
      cached_word = (cap_word == WSEL_YPOS) || (cap_word == WSEL_LINK);
      cap_hit     = wr_en && in_window && cached_word;
   end

endmodule

// File: rtl/stc_entry_store.sv
module stc_entry_store
   import stc_pkg::*;
#(
   parameter int N_ENT = 80,
   parameter int IDX_W = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap_hit,
   input  logic [IDX_W-1:0]        cap_entry,
   input  stc_wsel_e               cap_word,
   input  logic [STC_WORD_W-1:0]   wr_data,
   output stc_entry_t [N_ENT-1:0]  table_q
);

   if (N_ENT > (1 << IDX_W)) begin : g_bad_depth
      $error("stc_entry_store: IDX_W cannot address N_ENT entries");
   end

   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      logic sel;
      assign sel = cap_hit && (cap_entry == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            table_q[g] <= '0;
         end else if (sel) begin
            if (cap_word == WSEL_YPOS) table_q[g].ypos <= wr_data;
            else                       table_q[g].link <= wr_data;
         end
      end
   end

endmodule

// File: rtl/stc_read_port.sv
module stc_read_port
   import stc_pkg::*;
#(
   parameter int N_ENT   = 80,
   parameter int IDX_W   = 7,
   parameter bit FORWARD = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [IDX_W-1:0]        rd_idx,
   input  stc_entry_t [N_ENT-1:0]  table_q,
   input  logic                    cap_hit,
   input  logic [IDX_W-1:0]        cap_entry,
   input  stc_wsel_e               cap_word,
   input  logic [STC_WORD_W-1:0]   wr_data,
   output stc_entry_t              rd_q
);

   localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(N_ENT);

   logic       idx_ok;
   stc_entry_t raw;
   stc_entry_t nxt;

   always_comb begin
      idx_ok = rd_idx < IDX_LIM;
      raw    = '0;
      for (int i = 0; i < N_ENT; i++) begin
         if (rd_idx == IDX_W'(i)) raw = table_q[i];
      end
   end

   if (FORWARD) begin : g_fwd
      always_comb begin
         nxt = raw;
         if (cap_hit && idx_ok && (cap_entry == rd_idx)) begin
            if (cap_word == WSEL_YPOS) nxt.ypos = wr_data;
            else                       nxt.link = wr_data;
         end
      end
   end else begin : g_nofwd
      always_comb nxt = raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rd_q <= '0;
      else if (idx_ok) rd_q <= nxt;
      else             rd_q <= '0;
   end

endmodule

// File: rtl/sprite_attr_cache.sv
module sprite_attr_cache
   import stc_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int N_WIDE      = 80,
   parameter int N_NARROW    = 64,
   parameter int ENTRY_BYTES = 8,
   parameter bit FORWARD     = 1'b1,
   localparam int IDX_W      = $clog2(N_WIDE)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wide_mode,
   input  logic [ADDR_W-1:0]     tbl_base,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [STC_WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [STC_WORD_W-1:0] rd_ypos,
   output logic [STC_WORD_W-1:0] rd_link
);

   if (N_NARROW > N_WIDE) begin : g_bad_modes
      $error("sprite_attr_cache: narrow window exceeds wide window");
   end

   logic                   cap_hit;
   logic [IDX_W-1:0]       cap_entry;
   stc_wsel_e              cap_word;
   stc_entry_t [N_WIDE-1:0] table_q;
   stc_entry_t             rd_q;

   stc_snoop_decode #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .N_WIDE(N_WIDE),
      .N_NARROW(N_NARROW), .ENTRY_BYTES(ENTRY_BYTES)
   ) u_dec (
      .wide_mode(wide_mode), .tbl_base(tbl_base), .wr_en(wr_en),
      .wr_addr(wr_addr), .cap_hit(cap_hit), .cap_entry(cap_entry),
      .cap_word(cap_word)
   );

   stc_entry_store #(.N_ENT(N_WIDE), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .cap_hit(cap_hit), .cap_entry(cap_entry),
      .cap_word(cap_word), .wr_data(wr_data), .table_q(table_q)
   );

   stc_read_port #(.N_ENT(N_WIDE), .IDX_W(IDX_W), .FORWARD(FORWARD)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .table_q(table_q),
      .cap_hit(cap_hit), .cap_entry(cap_entry), .cap_word(cap_word),
      .wr_data(wr_data), .rd_q(rd_q)
   );

   assign rd_ypos = rd_q.ypos;
   assign rd_link = rd_q.link;

endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
   parameter int N_WIDE   = 80,
   parameter int N_NARROW = 64,
   parameter int IDX_W    = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wide_mode,
   input logic [IDX_W-1:0] rd_idx,
   input logic [15:0]      wr_data,
   input logic [15:0]      rd_ypos,
   input logic [15:0]      rd_link,
   input logic             cap_hit,
   input logic [IDX_W-1:0] cap_entry,
   input logic [1:0]       cap_word
);

   // R1: outputs are zero at the edge where reset is released
   a_r1_reset_clears: assert property (@(posedge clk)
      $rose(rst_n) |-> (rd_ypos == 16'd0 && rd_link == 16'd0));

   // R5: narrow mode never captures into entries 64 and up
   a_r5_narrow_window: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_hit && !wide_mode) |-> (cap_entry < IDX_W'(N_NARROW)));

   // R9: steady index and no capture keeps the outputs steady
   a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_hit && $stable(rd_idx)) |=> ($stable(rd_ypos) && $stable(rd_link)));

   // R10: same-entry write forwards to the read port
   a_r10_ypos_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_hit && cap_word == 2'd0 && cap_entry == rd_idx) |=> (rd_ypos == $past(wr_data)));

   a_r10_link_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_hit && cap_word == 2'd1 && cap_entry == rd_idx) |=> (rd_link == $past(wr_data)));

   // R11: indices beyond the table read as zero
   a_r11_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx >= IDX_W'(N_WIDE)) |=> (rd_ypos == 16'd0 && rd_link == 16'd0));

endmodule

bind sprite_attr_cache stc_checker #(
   .N_WIDE(N_WIDE), .N_NARROW(N_NARROW), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .rd_idx(rd_idx),
   .wr_data(wr_data), .rd_ypos(rd_ypos), .rd_link(rd_link),
   .cap_hit(cap_hit), .cap_entry(cap_entry), .cap_word(cap_word)
);

// File: tb/sim_sprite_attr_cache.sv
`timescale 1ns/1ps
module sim_sprite_attr_cache;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b1;
   logic [15:0] tbl_base = 16'hC000;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = 16'h0000;
   logic [15:0] wr_data = 16'h0000;
   logic [6:0]  rd_idx = 7'd0;
   logic [15:0] rd_ypos;
   logic [15:0] rd_link;

   always #2.5 clk = ~clk;

   sprite_attr_cache u0 (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .tbl_base(tbl_base),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_idx(rd_idx),
      .rd_ypos(rd_ypos), .rd_link(rd_link)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit cmp_on = 1'b0;
   bit done = 1'b0;

   // behavioural reference model
   logic [15:0] m_y [80];
   logic [15:0] m_l [80];
   logic [15:0] e_y = 16'h0;
   logic [15:0] e_l = 16'h0;

   always @(posedge clk) begin
      logic [15:0] off;
      int ix;
      if (!rst_n) begin
         for (int i = 0; i < 80; i++) begin m_y[i] = 16'h0; m_l[i] = 16'h0; end
         e_y = 16'h0; e_l = 16'h0;
      end else begin
         off = wr_addr - tbl_base;
         if (wr_en && off < (wide_mode ? 16'd640 : 16'd512) && off[2:1] < 2'd2) begin
            ix = int'(off) / 8;
            if (off[2:1] == 2'd0) m_y[ix] = wr_data;
            else                  m_l[ix] = wr_data;
         end
         ix = int'(rd_idx);
         if (ix < 80) begin e_y = m_y[ix]; e_l = m_l[ix]; end
         else         begin e_y = 16'h0;  e_l = 16'h0;  end
      end
   end

   // R9: every cycle the registered outputs match the model
   always @(negedge clk) begin
      if (cmp_on && !done) begin
         n_chk++;
         if (rd_ypos !== e_y || rd_link !== e_l) begin
            n_bad++;
            $display("FAIL R9 model: actual %h/%h expected %h/%h", rd_ypos, rd_link, e_y, e_l);
         end
      end
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int idx, input logic [15:0] ey, input logic [15:0] el, input string tag);
      @(negedge clk);
      rd_idx = 7'(idx);
      @(negedge clk);
      chk(tag, rd_ypos, ey);
      chk(tag, rd_link, el);
   endtask

   task automatic report();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #1000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset ypos", rd_ypos, 16'h0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      rd(0,  16'h0, 16'h0, "R1 entry 0");
      rd(79, 16'h0, 16'h0, "R1 entry 79");

      wr(16'hC028, 16'h0123);                 // entry 5 word 0
      rd(5, 16'h0123, 16'h0000, "R2 ypos capture");
      wr(16'hC02A, 16'h0506);                 // entry 5 word 1
      rd(5, 16'h0123, 16'h0506, "R3 link capture");
      wr(16'hC02C, 16'hFFFF);                 // word 2
      wr(16'hC02E, 16'hEEEE);                 // word 3
      rd(5, 16'h0123, 16'h0506, "R4 words 2/3 ignored");

      wr(16'hC230, 16'h0AAA);                 // entry 70 word 0, wide
      wr(16'hC232, 16'h0BBB);
      rd(70, 16'h0AAA, 16'h0BBB, "R6 wide high entry");

      @(negedge clk); wide_mode = 1'b0;
      wr(16'hC230, 16'h1111);
      wr(16'hC232, 16'h2222);
      rd(70, 16'h0AAA, 16'h0BBB, "R5 narrow drops entry 70");
      wr(16'hC1F8, 16'h0777);                 // entry 63
      rd(63, 16'h0777, 16'h0000, "R5 narrow entry 63");

      @(negedge clk); wide_mode = 1'b1;
      rd(70, 16'h0AAA, 16'h0BBB, "R7 stale after return");

      wr(16'hBFF8, 16'h3333);                 // below base
      wr(16'hC280, 16'h4444);                 // offset 640
      wr(16'hC3F8, 16'h5555);                 // offset 1016
      rd(0,  16'h0, 16'h0, "R8 entry 0 untouched");
      rd(79, 16'h0, 16'h0, "R8 entry 79 untouched");

      rd(100, 16'h0, 16'h0, "R11 index 100");
      rd(80,  16'h0, 16'h0, "R11 index 80");

      @(negedge clk);
      wr_en = 1'b1; wr_addr = 16'hC050; wr_data = 16'h4242; rd_idx = 7'd10;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R10 forward ypos", rd_ypos, 16'h4242);
      wr_en = 1'b1; wr_addr = 16'hC052; wr_data = 16'h5A5A;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R10 forward link", rd_link, 16'h5A5A);
      chk("R9 held ypos", rd_ypos, 16'h4242);

      for (int k = 0; k < 80; k++) begin
         wr(16'hC000 + 16'(k * 8), 16'(k + 16'h100));
      end
      for (int k = 0; k < 80; k += 13) begin
         rd(k, 16'(k + 16'h100), (k == 5) ? 16'h0506 : ((k == 70) ? 16'h0BBB : 16'h0), "R2 sweep");
      end

      repeat (4) @(negedge clk);
      report();
   end

endmodule